// File: doc/BRIEF.md
# End-of-Interrupt Broadcast Engine with Storm Throttle

This block sits beside an interrupt redirection table and handles end-of-interrupt notifications. A one-cycle strobe carries an interrupt vector. The engine accepts it and walks the pins of the table one per cycle. For each pin it tests whether the entry belongs to that vector. A pin qualifies only when it is level-triggered and has its remote-IRR flag set. For a qualifying pin the engine pulses that pin's clear strobe, and the table owner uses the strobe to drop remote-IRR. The engine then decides whether the pin needs redelivery, because it is unmasked and its input is still asserted.

A counter for each vector value tracks how many redeliveries happened back to back. A normal redelivery raises a one-cycle service request in the same cycle as the clear strobe. Once the count for a vector reaches a threshold, the counter restarts from zero. The service pass is then postponed by a fixed number of clock cycles, so software that mishandles a level interrupt still makes progress. A postponed pass that is already waiting is never pushed back.

The table contents are inputs and are assumed stable while a scan runs. Message formation and register decoding are handled elsewhere.

Top module: `eoi_storm_guard`

## Requirements
- R1: A pin matches only when its vector field (`pinVector[i*VEC_W +: VEC_W]`) equals the accepted vector, `pinLevel[i]` is 1 (level mode) and `pinRemoteIrr[i]` is 1. Other pins get no clear strobe and cause no service request.
- R2: If a vector is accepted at clock edge A, pin i is examined at edge A+1+i. For a matching pin, `clrRemoteIrr` is one-hot on bit i for exactly the cycle after that edge.
- R3: For a matching pin with `pinMasked[i]`=0 and `pinIrr[i]`=1, the vector's counter is incremented. If the new value is below THRESH, `serviceReq` pulses in the same cycle as the clear strobe.
- R4: For a matching pin that is masked or whose `pinIrr[i]` is 0, the vector's counter returns to zero and no service request is raised.
- R5: When an increment would reach THRESH, the counter returns to zero and there is no immediate request. A single `serviceReq` pulse follows DELAY_CYCLES cycles after the clear strobe.
- R6: If a postponed pass is already waiting when another deferral occurs, the earlier expiry is kept and only one postponed pulse is produced.
- R7: `busy` is high for the NPINS cycles of a scan. An `eoiValid` strobe that arrives while `busy` is high is ignored.
- R8: After reset, `busy`, `clrRemoteIrr` and `serviceReq` are zero, and every counter is zero.
- R9: Counters are kept for each vector value. Activity on one vector does not change the count of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| eoiValid | input | 1 | End-of-interrupt strobe |
| eoiVector | input | VEC_W | Vector carried by the strobe |
| pinVector | input | NPINS*VEC_W | Vector field of each table entry |
| pinLevel | input | NPINS | 1 = entry is level-triggered |
| pinRemoteIrr | input | NPINS | Remote-IRR flag of each entry |
| pinMasked | input | NPINS | Mask flag of each entry |
| pinIrr | input | NPINS | Current request state of each pin |
| busy | output | 1 | Scan in progress |
| clrRemoteIrr | output | NPINS | One-hot strobe to clear remote-IRR |
| serviceReq | output | 1 | Request one service pass of the table |

## Verification
The bench builds the engine with four pins, a threshold of 3 and a postponement of 20 cycles, and keeps the 8-bit vector width. With a threshold of 3, a storm appears after three back-to-back redeliveries. Four pins sharing one vector can therefore trigger two deferrals within one postponement window, which exercises the kept-expiry rule. Twenty cycles is longer than a scan, so postponed pulses never collide with clear strobes, and the exact expiry cycle can be predicted.

// File: rtl/eoi_pkg.sv
package eoi_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scanState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchVec;
    logic scanStep;
  } eoiCtl_t;

  // per-pin verdict from datapath to control
  typedef struct packed {
    logic hit;
    logic redeliver;
    logic defer;
  } eoiStat_t;

endpackage

// File: rtl/eoi_dp.sv
module eoi_dp
  import eoi_pkg::*;
#(
  parameter int NPINS  = 24,
  parameter int VEC_W  = 8,
  parameter int THRESH = 10000,
  parameter int PIN_W  = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  eoiCtl_t                ctl,
  input  logic [VEC_W-1:0]       eoiVector,
  input  logic [PIN_W-1:0]       scanIdx,
  input  logic [NPINS*VEC_W-1:0] pinVector,
  input  logic [NPINS-1:0]       pinLevel,
  input  logic [NPINS-1:0]       pinRemoteIrr,
  input  logic [NPINS-1:0]       pinMasked,
  input  logic [NPINS-1:0]       pinIrr,
  output eoiStat_t               stat
);

  localparam int NVEC  = 1 << VEC_W;
  localparam int CNT_W = $clog2(THRESH + 1);

  logic [VEC_W-1:0] latchedVec;
  logic [VEC_W-1:0] curVec;
  logic [CNT_W-1:0] cntAll [NVEC];
  logic [CNT_W-1:0] curCnt;
  logic [CNT_W-1:0] nextCnt;
  logic [CNT_W-1:0] wrVal;
  logic             live;
  logic             reach;
  logic             wrEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchedVec <= '0;
    end else if (ctl.latchVec) begin
      latchedVec <= eoiVector;
    end
  end

  assign curVec  = pinVector[scanIdx*VEC_W +: VEC_W];
  assign live    = !pinMasked[scanIdx] && pinIrr[scanIdx];
  assign curCnt  = cntAll[latchedVec];
  assign nextCnt = curCnt + 1'b1;
  assign reach   = nextCnt >= CNT_W'(THRESH);

  always_comb begin
    stat.hit       = (curVec == latchedVec) && pinLevel[scanIdx] && pinRemoteIrr[scanIdx];
    stat.redeliver = stat.hit && live && !reach;
    stat.defer     = stat.hit && live && reach;
  end

  assign wrEn  = ctl.scanStep && stat.hit;
  assign wrVal = stat.redeliver ? nextCnt : '0;

  // one run-length counter per vector value
  for (genvar g = 0; g < NVEC; g++) begin : gCnt
    logic [CNT_W-1:0] cntQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntQ <= '0;
      end else if (wrEn && (latchedVec == VEC_W'(g))) begin
        cntQ <= wrVal;
      end
    end
    assign cntAll[g] = cntQ;
  end

  // R5: the counter of the vector under scan never holds the threshold
  a_r5_cnt_below_thresh: assert property (@(posedge clk) disable iff (!rstN)
    curCnt < CNT_W'(THRESH));

  // R9: a step updates only the latched vector's counter, so the latch is frozen during a scan
  a_r9_vec_frozen: assert property (@(posedge clk) disable iff (!rstN)
    ctl.scanStep |=> $stable(latchedVec));

endmodule

// File: rtl/eoi_ctrl.sv
module eoi_ctrl
  import eoi_pkg::*;
#(
  parameter int NPINS        = 24,
  parameter int DELAY_CYCLES = 500000,
  parameter int PIN_W        = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             eoiValid,
  input  eoiStat_t         stat,
  output eoiCtl_t          ctl,
  output logic [PIN_W-1:0] scanIdx,
  output logic             busy,
  output logic [NPINS-1:0] clrRemoteIrr,
  output logic             serviceReq
);

  localparam int TMR_W = $clog2(DELAY_CYCLES + 1);
  localparam logic [PIN_W-1:0] LAST_IDX = PIN_W'(NPINS - 1);

  scanState_e       state;
  logic             scanning;
  logic             pending;
  logic [TMR_W-1:0] tmr;
  logic             expire;
  logic             schedule;

  assign scanning     = (state == ST_SCAN);
  assign busy         = scanning;
  assign ctl.latchVec = !scanning && eoiValid;
  assign ctl.scanStep = scanning;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      scanIdx <= '0;
    end else if (!scanning) begin
      if (eoiValid) begin
        state   <= ST_SCAN;
        scanIdx <= '0;
      end
    end else if (scanIdx == LAST_IDX) begin
      state   <= ST_IDLE;
      scanIdx <= '0;
    end else begin
      scanIdx <= scanIdx + 1'b1;
    end
  end

  // postponed service timer, armed only when idle or expiring
  assign expire   = pending && (tmr == TMR_W'(1));
  assign schedule = scanning && stat.defer;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
      tmr     <= '0;
    end else if (schedule && (!pending || expire)) begin
      pending <= 1'b1;
      tmr     <= TMR_W'(DELAY_CYCLES);
    end else if (expire) begin
      pending <= 1'b0;
      tmr     <= '0;
    end else if (pending) begin
      tmr <= tmr - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clrRemoteIrr <= '0;
      serviceReq   <= 1'b0;
    end else begin
      clrRemoteIrr <= (scanning && stat.hit) ? (NPINS'(1) << scanIdx) : '0;
      serviceReq   <= (scanning && stat.redeliver) || expire;
    end
  end

  a_r2_clr_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(clrRemoteIrr));

  a_r7_clr_only_after_scan: assert property (@(posedge clk) disable iff (!rstN)
    (clrRemoteIrr != '0) |-> $past(busy));

  a_r7_scan_advances: assert property (@(posedge clk) disable iff (!rstN)
    (busy && scanIdx != LAST_IDX) |=> (busy && scanIdx == $past(scanIdx) + 1'b1));

  a_r5_timer_in_range: assert property (@(posedge clk) disable iff (!rstN)
    pending |-> (tmr != '0 && tmr <= TMR_W'(DELAY_CYCLES)));

  a_r6_keep_expiry: assert property (@(posedge clk) disable iff (!rstN)
    (pending && !expire) |=> (pending && tmr == $past(tmr) - 1'b1));

endmodule

// File: rtl/eoi_storm_guard.sv
module eoi_storm_guard
  import eoi_pkg::*;
#(
  parameter int NPINS        = 24,
  parameter int VEC_W        = 8,
  parameter int THRESH       = 10000,
  parameter int DELAY_CYCLES = 500000
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   eoiValid,
  input  logic [VEC_W-1:0]       eoiVector,
  input  logic [NPINS*VEC_W-1:0] pinVector,
  input  logic [NPINS-1:0]       pinLevel,
  input  logic [NPINS-1:0]       pinRemoteIrr,
  input  logic [NPINS-1:0]       pinMasked,
  input  logic [NPINS-1:0]       pinIrr,
  output logic                   busy,
  output logic [NPINS-1:0]       clrRemoteIrr,
  output logic                   serviceReq
);

  localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1;

  eoiCtl_t          ctl;
  eoiStat_t         stat;
  logic [PIN_W-1:0] scanIdx;

  eoi_ctrl #(
    .NPINS(NPINS), .DELAY_CYCLES(DELAY_CYCLES), .PIN_W(PIN_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .eoiValid(eoiValid), .stat(stat), .ctl(ctl),
    .scanIdx(scanIdx), .busy(busy), .clrRemoteIrr(clrRemoteIrr),
    .serviceReq(serviceReq)
  );

  eoi_dp #(
    .NPINS(NPINS), .VEC_W(VEC_W), .THRESH(THRESH), .PIN_W(PIN_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .eoiVector(eoiVector), .scanIdx(scanIdx),
    .pinVector(pinVector), .pinLevel(pinLevel), .pinRemoteIrr(pinRemoteIrr),
    .pinMasked(pinMasked), .pinIrr(pinIrr), .stat(stat)
  );

endmodule

// File: tb/sim_eoi_storm_guard.sv
module sim_eoi_storm_guard;

  localparam int NP = 4;
  localparam int VW = 8;
  localparam int TH = 3;
  localparam int DL = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic eoiValid = 1'b0;
  logic [VW-1:0] eoiVector = '0;
  logic [NP*VW-1:0] pinVector;
  logic [NP-1:0] pinLevel = '0, pinRemoteIrr = '0, pinMasked = '0, pinIrr = '0;
  logic busy, serviceReq;
  logic [NP-1:0] clrRemoteIrr;
  logic [VW-1:0] pVec [NP];

  always #10 clk = ~clk;

  always_comb for (int i = 0; i < NP; i++) pinVector[i*VW +: VW] = pVec[i];

  eoi_storm_guard #(.NPINS(NP), .VEC_W(VW), .THRESH(TH), .DELAY_CYCLES(DL)) u0 (
    .clk(clk), .rstN(rstN), .eoiValid(eoiValid), .eoiVector(eoiVector),
    .pinVector(pinVector), .pinLevel(pinLevel), .pinRemoteIrr(pinRemoteIrr),
    .pinMasked(pinMasked), .pinIrr(pinIrr), .busy(busy),
    .clrRemoteIrr(clrRemoteIrr), .serviceReq(serviceReq)
  );

  typedef struct {
    int            due;
    logic [NP-1:0] clr;
    logic          svc;
    logic [23:0]   tag;
  } ev_t;

  ev_t q[$];
  int  cyc = 0;
  int  errors = 0;
  int  checks = 0;
  int  cntM [256];
  bit  pendM = 0;
  int  dueM = 0;
  bit  monOn = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input logic [23:0] tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle=%0d actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  // monitor: pops expected items when the design produces them
  always @(negedge clk) begin
    if (monOn) begin : mon
      logic [NP-1:0] eClr;
      logic          eSvc;
      logic [23:0]   eTag;
      eClr = '0; eSvc = 1'b0; eTag = "R1";
      if (q.size() > 0 && q[0].due == cyc) begin
        eClr = q[0].clr; eSvc = q[0].svc; eTag = q[0].tag;
        void'(q.pop_front());
      end
      if (pendM && dueM == cyc) begin
        eSvc = 1'b1; eTag = "R5"; pendM = 0;
      end
      if (eClr != '0 || eSvc || clrRemoteIrr != '0 || serviceReq)
        check((clrRemoteIrr == eClr) && (serviceReq == eSvc), eTag,
              {clrRemoteIrr, serviceReq}, {eClr, eSvc});
    end
  end

  // driver: predicts events from the requirements, then issues the strobe
  task automatic doEoi(input logic [VW-1:0] v, input bit poke, input logic [VW-1:0] pv);
    int k;
    @(negedge clk);
    k = cyc;
    for (int i = 0; i < NP; i++) begin
      if (pVec[i] == v && pinLevel[i] && pinRemoteIrr[i]) begin  // R1 match rule
        ev_t e;
        e.due = k + 2 + i;  // R2 timing
        e.clr = NP'(1) << i;
        if (!pinMasked[i] && pinIrr[i]) begin
          if (cntM[v] + 1 >= TH) begin
            cntM[v] = 0;
            e.svc = 1'b0;
            if (!pendM) begin pendM = 1; dueM = e.due + DL; e.tag = "R5"; end
            else e.tag = "R6";
          end else begin
            cntM[v] = cntM[v] + 1; e.svc = 1'b1; e.tag = "R3";
          end
        end else begin
          cntM[v] = 0; e.svc = 1'b0; e.tag = "R4";
        end
        q.push_back(e);
      end
    end
    eoiVector = v; eoiValid = 1'b1;
    @(negedge clk);
    eoiValid = 1'b0;
    check(busy == 1'b1, "R7", busy, 1);
    if (poke) begin
      eoiVector = pv; eoiValid = 1'b1;  // R7: must be ignored
      @(negedge clk);
      eoiValid = 1'b0;
      repeat (NP - 1) @(negedge clk);
    end else begin
      repeat (NP) @(negedge clk);
    end
    check(busy == 1'b0, "R7", busy, 0);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R2 watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) cntM[i] = 0;
    pVec[0] = 8'h31; pVec[1] = 8'h31; pVec[2] = 8'h32; pVec[3] = 8'h31;
    pinLevel = 4'b0101; pinRemoteIrr = 4'b0111; pinMasked = 4'b0000; pinIrr = 4'b1111;
    settle(3);
    rstN = 1'b1;
    @(negedge clk);
    // R8: reset state at the ports
    check(busy == 1'b0, "R8", busy, 0);
    check(clrRemoteIrr == '0, "R8", clrRemoteIrr, 0);
    check(serviceReq == 1'b0, "R8", serviceReq, 0);
    monOn = 1;

    // R1: only pin 0 qualifies (pin1 edge, pin2 other vector, pin3 no remote-IRR)
    doEoi(8'h31, 0, 8'h00);
    // R1: vector with no match gives nothing
    doEoi(8'h99, 0, 8'h00);
    // R4: masked pin, then idle input
    pinMasked[0] = 1'b1; doEoi(8'h31, 0, 8'h00); pinMasked[0] = 1'b0;
    pinIrr[0] = 1'b0;    doEoi(8'h31, 0, 8'h00); pinIrr[0] = 1'b1;
    // R3 then R5: three back-to-back redeliveries
    doEoi(8'h31, 0, 8'h00);
    doEoi(8'h31, 0, 8'h00);
    doEoi(8'h31, 0, 8'h00);
    settle(DL + 5);

    // R6: four pins on one vector, two deferrals inside one window
    for (int i = 0; i < NP; i++) pVec[i] = 8'h40;
    pinLevel = '1; pinRemoteIrr = '1;
    doEoi(8'h40, 0, 8'h00);
    doEoi(8'h40, 0, 8'h00);
    settle(DL + 10);

    // R9: another vector counts on its own
    pVec[0] = 8'h55;
    doEoi(8'h55, 0, 8'h00);
    doEoi(8'h55, 0, 8'h00);
    doEoi(8'h40, 0, 8'h00);
    settle(DL + 5);

    // R7: strobe during scan is dropped
    doEoi(8'h55, 1, 8'h40);
    settle(DL + 5);

    // R2: every predicted strobe was observed
    check(q.size() == 0, "R2", q.size(), 0);
    check(!pendM, "R5", pendM, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule